// File: doc/BRIEF.md
# Tiled Matrix-Multiply Loop Sequencer

This controller steps through the outer tile loops of a matrix product Out = W x In, where W has M rows and K reduction terms and In has K terms by N columns. The product is split into tiles of TM rows and TN columns. A start pulse begins one pass over the tiles. For each tile the controller sends commands to a compute array over a valid/ready handshake. It also produces the scratchpad addresses that feed operands in and let results drain out. The array and the memories are outside the block.

The tile loops are nested with the row tile outermost, the reduction slice in the middle and the column tile innermost. Weights stay resident across all column tiles of one row tile. A weight load is issued only when the column-tile counter has wrapped to zero. Loops with a single iteration generate no counter and no reload, so with the default shapes the reduction loop disappears and weights are fetched once per row tile, 8 times in all.

The scratchpads are organised in vector words. One word holds a full reduction slice of KP*KE elements. The weight word for row m and slice k is at m*KT+k, and the input word for column n is at n*KT+k. Each result element is written individually, at the row-major address m*N+n.

Top module: `matmul_tile_seq`

## Requirements
- R1: While reset is held, and afterwards while idle, busy, done, cmd_valid and all three memory strobes are low.
- R2: A load-weights command (cmd_op = 0) is issued at the start of a row tile and never for a column tile other than zero. After its handshake, TM weight reads follow, one per cycle, at addresses m*KT+k for m = m_tile*TM + 0..TM-1 in ascending order. A full pass issues 8 such commands.
- R3: For each tile, a run command (cmd_op = 1) is followed by TN input reads, one per cycle, at addresses n*KT+k for n = n_tile*TN + 0..TN-1 in ascending order.
- R4: After the last reduction slice of a tile, a drain command (cmd_op = 2) is followed by TM*TN output writes, one per cycle. They go in row-major order (row outer, column inner) at address m*N + n.
- R5: Tiles are visited with the row tile outermost and the column tile innermost. A full pass issues 128 run commands and the complete event sequence matches a software loop nest.
- R6: Once cmd_valid is raised it stays high, with cmd_op unchanged, until a cycle in which cmd_ready is high. No memory strobe of the commanded phase appears before that handshake.
- R7: done is high for exactly one cycle, the cycle right after the final output write. busy is high from the cycle after start until that cycle, and low in it.
- R8: A start pulse while busy is ignored: the running pass continues unchanged.
- R9: At most one of the weight-read, input-read and output-write strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a pass (ignored while busy) |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle pulse after the final output write |
| cmd_valid | output | 1 | Command offered to the array |
| cmd_ready | input | 1 | Array accepts the command |
| cmd_op | output | 2 | 0 load weights, 1 run, 2 drain |
| w_rd_en | output | 1 | Weight scratchpad read strobe |
| w_addr | output | 7 | Weight word address |
| in_rd_en | output | 1 | Input scratchpad read strobe |
| in_addr | output | 8 | Input word address |
| out_wr_en | output | 1 | Output scratchpad write strobe |
| out_addr | output | 15 | Output element address |

## Verification
The hardest situations to reach are the command boundaries under backpressure. The last strobe of one phase shares a cycle with cmd_valid of the next, and the array may then hold cmd_ready low for many cycles. The bench repeats a full pass with three cmd_ready patterns: always ready, a short periodic stall, and long stalls that keep commands waiting. Every strobe and handshake is compared against a loop-nest model. Stray start pulses are injected in the middle of the pass to confirm that it is neither restarted nor disturbed.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {
    OP_LOADW = 2'd0,
    OP_RUN   = 2'd1,
    OP_DRAIN = 2'd2
  } seq_op_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_CMD  = 2'd1,
    S_STRM = 2'd2,
    S_FIN  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/tile_loop_ctr.sv
module tile_loop_ctr #(
  parameter int MT = 8,
  parameter int KT = 1,
  parameter int NT = 16,
  localparam int MW = (MT > 1) ? $clog2(MT) : 1,
  localparam int KW = (KT > 1) ? $clog2(KT) : 1,
  localparam int NW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          step,
  output logic [MW-1:0] m_idx,
  output logic [KW-1:0] k_idx,
  output logic [NW-1:0] n_idx,
  output logic          last_n,
  output logic          last_k,
  output logic          last_all
);
  logic adv_k;
  logic adv_m;

  assign last_n   = (n_idx == NW'(NT - 1));
  assign adv_k    = step && last_n;
  assign adv_m    = adv_k && last_k;
  assign last_all = last_n && last_k && (m_idx == MW'(MT - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      n_idx <= '0;
      m_idx <= '0;
    end else begin
      if (step)  n_idx <= last_n ? '0 : n_idx + 1'b1;
      if (adv_m) m_idx <= m_idx + 1'b1;
    end
  end

  // a single-slice reduction loop is elided: no counter, no reload event
  generate
    if (KT == 1) begin : g_k_elided
      assign k_idx  = '0;
      assign last_k = 1'b1;
    end else begin : g_k_loop
      always_ff @(posedge clk) begin
        if (rst || clear)  k_idx <= '0;
        else if (adv_k)    k_idx <= (k_idx == KW'(KT - 1)) ? '0 : k_idx + 1'b1;
      end
      assign last_k = (k_idx == KW'(KT - 1));
    end
  endgenerate

  // R5
  n_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !clear && last_n) |=> (n_idx == '0));
endmodule

// File: rtl/tile_addr_gen.sv
module tile_addr_gen
  import seq_pkg::*;
#(
  parameter int M  = 128,
  parameter int N  = 256,
  parameter int KT = 1,
  parameter int TM = 16,
  parameter int TN = 16,
  parameter int MW = 3,
  parameter int KW = 1,
  parameter int NW = 4,
  parameter int CW = 9,
  localparam int WAW = (M * KT > 1) ? $clog2(M * KT) : 1,
  localparam int IAW = (N * KT > 1) ? $clog2(N * KT) : 1,
  localparam int OAW = (M * N > 1) ? $clog2(M * N) : 1,
  localparam int LTN = (TN > 1) ? $clog2(TN) : 0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  seq_op_e        op,
  input  logic [CW-1:0]  cnt,
  input  logic [MW-1:0]  m_idx,
  input  logic [KW-1:0]  k_idx,
  input  logic [NW-1:0]  n_idx,
  output logic           w_rd_en,
  output logic [WAW-1:0] w_addr,
  output logic           in_rd_en,
  output logic [IAW-1:0] in_addr,
  output logic           out_wr_en,
  output logic [OAW-1:0] out_addr
);
  int row_w, col_in, row_o, col_o;

  always_comb begin
    // m = m_tile*TM + m_par (m_pe has one step), n = n_tile*TN + n_pe
    row_w  = int'(m_idx) * TM + int'(cnt);
    col_in = int'(n_idx) * TN + int'(cnt);
    row_o  = int'(m_idx) * TM + (int'(cnt) >> LTN);
    col_o  = int'(n_idx) * TN + (int'(cnt) & (TN - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      w_rd_en   <= 1'b0;
      in_rd_en  <= 1'b0;
      out_wr_en <= 1'b0;
      w_addr    <= '0;
      in_addr   <= '0;
      out_addr  <= '0;
    end else begin
      w_rd_en   <= en && (op == OP_LOADW);
      in_rd_en  <= en && (op == OP_RUN);
      out_wr_en <= en && (op == OP_DRAIN);
      w_addr    <= WAW'(row_w * KT + int'(k_idx));
      in_addr   <= IAW'(col_in * KT + int'(k_idx));
      out_addr  <= OAW'(row_o * N + col_o);
    end
  end

  // R9
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({w_rd_en, in_rd_en, out_wr_en}));
endmodule

// File: rtl/matmul_tile_seq.sv
module matmul_tile_seq
  import seq_pkg::*;
#(
  parameter int M  = 128,
  parameter int K  = 64,
  parameter int N  = 256,
  parameter int TM = 16,
  parameter int TN = 16,
  parameter int KP = 16,
  parameter int KE = 4,
  localparam int KT  = K / (KP * KE),
  localparam int MT  = M / TM,
  localparam int NT  = N / TN,
  localparam int WAW = (M * KT > 1) ? $clog2(M * KT) : 1,
  localparam int IAW = (N * KT > 1) ? $clog2(N * KT) : 1,
  localparam int OAW = (M * N > 1) ? $clog2(M * N) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  output logic           busy,
  output logic           done,
  output logic           cmd_valid,
  input  logic           cmd_ready,
  output logic [1:0]     cmd_op,
  output logic           w_rd_en,
  output logic [WAW-1:0] w_addr,
  output logic           in_rd_en,
  output logic [IAW-1:0] in_addr,
  output logic           out_wr_en,
  output logic [OAW-1:0] out_addr
);
  localparam int MW = (MT > 1) ? $clog2(MT) : 1;
  localparam int KW = (KT > 1) ? $clog2(KT) : 1;
  localparam int NW = (NT > 1) ? $clog2(NT) : 1;
  localparam int CW = $clog2(TM * TN + 1);

  seq_state_e    state;
  seq_op_e       op_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] len_m1;
  logic          strm_last;
  logic          step, clear;
  logic [MW-1:0] m_idx;
  logic [KW-1:0] k_idx;
  logic [NW-1:0] n_idx;
  logic          last_n, last_k, last_all;

  always_comb begin
    case (op_q)
      OP_LOADW: len_m1 = CW'(TM - 1);
      OP_RUN:   len_m1 = CW'(TN - 1);
      default:  len_m1 = CW'(TM * TN - 1);
    endcase
  end

  assign strm_last = (state == S_STRM) && (cnt == len_m1);
  assign clear     = (state == S_IDLE) && start;
  assign step      = strm_last &&
                     (((op_q == OP_RUN) && !last_k) || ((op_q == OP_DRAIN) && !last_all));
  assign cmd_op    = op_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      op_q      <= OP_LOADW;
      cnt       <= '0;
      cmd_valid <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state     <= S_CMD;
          op_q      <= OP_LOADW;
          cmd_valid <= 1'b1;
          busy      <= 1'b1;
        end
        S_CMD: if (cmd_ready) begin
          cmd_valid <= 1'b0;
          cnt       <= '0;
          state     <= S_STRM;
        end
        S_STRM: begin
          if (!strm_last) begin
            cnt <= cnt + 1'b1;
          end else if (op_q == OP_DRAIN && last_all) begin
            state <= S_FIN;
          end else begin
            state     <= S_CMD;
            cmd_valid <= 1'b1;
            if (op_q == OP_LOADW)                 op_q <= OP_RUN;
            else if (op_q == OP_RUN && last_k)    op_q <= OP_DRAIN;
            else                                  op_q <= last_n ? OP_LOADW : OP_RUN;
          end
        end
        default: begin
          done  <= 1'b1;
          busy  <= 1'b0;
          state <= S_IDLE;
        end
      endcase
    end
  end

  tile_loop_ctr #(.MT(MT), .KT(KT), .NT(NT)) u_loops (
    .clk(clk), .rst(rst), .clear(clear), .step(step),
    .m_idx(m_idx), .k_idx(k_idx), .n_idx(n_idx),
    .last_n(last_n), .last_k(last_k), .last_all(last_all)
  );

  tile_addr_gen #(
    .M(M), .N(N), .KT(KT), .TM(TM), .TN(TN),
    .MW(MW), .KW(KW), .NW(NW), .CW(CW)
  ) u_addr (
    .clk(clk), .rst(rst), .en(state == S_STRM), .op(op_q), .cnt(cnt),
    .m_idx(m_idx), .k_idx(k_idx), .n_idx(n_idx),
    .w_rd_en(w_rd_en), .w_addr(w_addr),
    .in_rd_en(in_rd_en), .in_addr(in_addr),
    .out_wr_en(out_wr_en), .out_addr(out_addr)
  );

  // R6
  cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op)));
  // R2
  reload_at_first_col_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_op == 2'd0) |-> (n_idx == '0));
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R7
  done_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(out_wr_en) && !busy));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!cmd_valid && !w_rd_en && !in_rd_en));
endmodule

// File: tb/matmul_tile_seq_tb.sv
module matmul_tile_seq_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic cmd_ready = 1'b0;
  logic busy, done, cmd_valid, w_rd_en, in_rd_en, out_wr_en;
  logic [1:0]  cmd_op;
  logic [6:0]  w_addr;
  logic [7:0]  in_addr;
  logic [14:0] out_addr;

  always #2 clk = ~clk;  // 250 MHz

  matmul_tile_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .w_rd_en(w_rd_en), .w_addr(w_addr), .in_rd_en(in_rd_en), .in_addr(in_addr),
    .out_wr_en(out_wr_en), .out_addr(out_addr)
  );

  int n_chk = 0;
  int n_bad = 0;
  int rdy_mode = 0;
  int cyc = 0;
  bit mon_on = 1'b0;
  bit pend_done = 1'b0;
  int ex_m, ex_n, ex_ph, ex_i;
  int ldw_cnt, run_cnt;
  bit pv_valid, pv_ready;
  logic [1:0] pv_op;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // cmd_ready pattern, changed shortly after each rising edge
  initial forever begin
    @(posedge clk); #1;
    cyc++;
    case (rdy_mode)
      0:       cmd_ready = 1'b1;
      1:       cmd_ready = (cyc % 5) >= 2;
      default: cmd_ready = (cyc % 23) >= 17;
    endcase
  end

  // expected event model: kind 0 cmd, 1 weight read, 2 input read, 3 output write
  task automatic expect_event(input int kind, input int val);
    int ek, ev;
    if (ex_ph == 6) begin
      chk(1'b0, "R5 extra event", kind, -1);
      return;
    end
    case (ex_ph)
      0: begin ek = 0; ev = 0; end
      1: begin ek = 1; ev = ex_m * 16 + ex_i; end
      2: begin ek = 0; ev = 1; end
      3: begin ek = 2; ev = ex_n * 16 + ex_i; end
      4: begin ek = 0; ev = 2; end
      default: begin ek = 3; ev = (ex_m * 16 + ex_i / 16) * 256 + ex_n * 16 + ex_i % 16; end
    endcase
    if (ek == 0 && ev == 0)      chk(kind == ek && val == ev, "R2 load-weights cmd", kind * 100000 + val, ek * 100000 + ev);
    else if (ek == 0)            chk(kind == ek && val == ev, "R5 cmd order", kind * 100000 + val, ek * 100000 + ev);
    else if (ek == 1)            chk(kind == ek && val == ev, "R2 weight addr", kind * 100000 + val, ek * 100000 + ev);
    else if (ek == 2)            chk(kind == ek && val == ev, "R3 input addr", kind * 100000 + val, ek * 100000 + ev);
    else                         chk(kind == ek && val == ev, "R4 output addr", kind * 100000 + val, ek * 100000 + ev);
    case (ex_ph)
      1: if (++ex_i == 16)  begin ex_i = 0; ex_ph = 2; end
      3: if (++ex_i == 16)  begin ex_i = 0; ex_ph = 4; end
      5: if (++ex_i == 256) begin
           ex_i = 0;
           if (ex_n == 15) begin
             ex_n = 0; ex_m++;
             ex_ph = (ex_m == 8) ? 6 : 0;
             if (ex_ph == 6) pend_done = 1'b1;
           end else begin
             ex_n++; ex_ph = 2;
           end
         end
      default: ex_ph++;
    endcase
  endtask

  // monitor, sampling away from the active edge
  initial forever begin
    @(negedge clk);
    if (mon_on) begin
      if (pend_done) begin
        chk(done && !busy, "R7 done after last write", {busy, done}, 1);
        pend_done = 1'b0;
      end else if (done) begin
        chk(1'b0, "R7 spurious done", 1, 0);
      end
      if (pv_valid && !pv_ready)
        chk(cmd_valid && cmd_op == pv_op, "R6 command held", {cmd_valid, cmd_op}, {1'b1, pv_op});
      chk(int'(w_rd_en) + int'(in_rd_en) + int'(out_wr_en) <= 1, "R9 single strobe",
          int'(w_rd_en) + int'(in_rd_en) + int'(out_wr_en), 1);
      if (w_rd_en)   expect_event(1, int'(w_addr));
      if (in_rd_en)  expect_event(2, int'(in_addr));
      if (out_wr_en) expect_event(3, int'(out_addr));
      if (cmd_valid && cmd_ready) begin
        if (cmd_op == 2'd0) ldw_cnt++;
        if (cmd_op == 2'd1) run_cnt++;
        expect_event(0, int'(cmd_op));
      end
    end
    pv_valid = cmd_valid;
    pv_ready = cmd_ready;
    pv_op    = cmd_op;
  end

  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !done && !cmd_valid, "R1 reset control", {busy, done, cmd_valid}, 0);
    chk(!w_rd_en && !in_rd_en && !out_wr_en, "R1 reset strobes", {w_rd_en, in_rd_en, out_wr_en}, 0);
    @(posedge clk); #1 rst = 1'b0;
    repeat (5) @(negedge clk);
    chk(!busy && !cmd_valid && !w_rd_en && !in_rd_en && !out_wr_en, "R1 idle after reset",
        {busy, cmd_valid, w_rd_en, in_rd_en, out_wr_en}, 0);
  endtask

  task automatic t_pass(input int mode, input bit stray_starts);
    rdy_mode = mode;
    ex_m = 0; ex_n = 0; ex_ph = 0; ex_i = 0;
    ldw_cnt = 0; run_cnt = 0;
    mon_on = 1'b1;
    pulse_start();
    @(negedge clk);
    chk(busy, "R7 busy after start", busy, 1);
    if (stray_starts) begin
      repeat (700) @(posedge clk);
      pulse_start();
      repeat (9000) @(posedge clk);
      pulse_start();
      @(negedge clk);
      chk(busy, "R8 start while busy ignored", busy, 1);
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(ex_ph == 6, "R5 full sequence consumed", ex_ph, 6);
    chk(ldw_cnt == 8, "R2 weight load count", ldw_cnt, 8);
    chk(run_cnt == 128, "R5 run command count", run_cnt, 128);
    repeat (10) @(negedge clk);
    chk(!busy && !done && !cmd_valid && !w_rd_en && !in_rd_en && !out_wr_en,
        "R1 idle after pass", {busy, done, cmd_valid, w_rd_en, in_rd_en, out_wr_en}, 0);
    mon_on = 1'b0;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_pass(0, 1'b0);
    t_pass(1, 1'b0);
    t_pass(2, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule